// File: doc/BRIEF.md
# Low-Side Gate Drive Protection Controller

This block is the clocked decision logic behind a single non-inverting low-side gate driver. It forwards a logic command to a gate output. Three guards can hold that output low: an overcurrent trip, a supply undervoltage lockout, and a shared active-low enable/fault line. The line is wired-AND. The controller can pull it low through an open-drain request, and any external agent can pull it low as well. The controller reads the line's level back through `line_sense`.

All inputs are asynchronous and are synchronized internally. Overcurrent sensing is blanked for a fixed number of cycles after every turn-on edge of the gate, so the switch-on current spike is not mistaken for a fault. A supply dip counts as an undervoltage fault only if it lasts for a set number of consecutive cycles. A fault pulls the shared line low and keeps it low until two things are true: a minimum hold time has passed since the most recent fault event, and the cause of the fault has gone away. An external low on the line only gates the output and is never stored.

Top module: `gate_fault_ctrl`

## Requirements
- R1: When no fault is held and `line_sense` is high, `gate_out` takes the value that `cmd_in` had three rising clock edges earlier: two synchronizer stages and one output register.
- R2: During the first BLANK_CYC cycles after each rising edge of `gate_out`, `oc_flag` is ignored. A flag that goes away within that window leaves no fault behind: the gate keeps following the command and `line_pull` stays low.
- R3: If the synchronized `oc_flag` is high while the gate is on and the blanking window has expired, `gate_out` goes low and `line_pull` goes high on the same clock edge. For an asynchronous flag this is the third edge.
- R4: An undervoltage fault is raised only when the synchronized `uv_fall_low` has been high for UV_FILT_CYC consecutive cycles. A shorter dip has no effect on `gate_out` or `line_pull`.
- R5: After reset, the block stays in undervoltage lockout, with `gate_out` low and `line_pull` high, until `uv_rise_ok` is seen high while `uv_fall_low` is low.
- R6: While `line_pull` is high, `gate_out` is low, whatever `cmd_in` is.
- R7: `line_pull` falls only after CLEAR_CYC cycles have passed since the latest fault event, and only when the cause is gone. The cause is gone when the undervoltage lockout is inactive and the synchronized `oc_flag` is low. If the cause lasts longer than the hold time, the line is held until the cause clears.
- R8: A fault event that occurs while a fault is already being held restarts the hold time from that event.
- R9: An external low on `line_sense` forces `gate_out` low without setting `line_pull`. Once the line returns high, the gate follows `cmd_in` again.
- R10: While `rst` is high, `gate_out` is 0 and `line_pull` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_in | input | 1 | Asynchronous logic command for the gate, active high |
| oc_flag | input | 1 | Overcurrent comparator output, high when the sense voltage is above the limit |
| uv_rise_ok | input | 1 | Supply comparator output, high when the supply is above the turn-on threshold |
| uv_fall_low | input | 1 | Supply comparator output, high when the supply is below the turn-off threshold |
| line_sense | input | 1 | Sensed level of the shared enable/fault line, low means disabled |
| gate_out | output | 1 | Gate command to the output stage |
| line_pull | output | 1 | Open-drain pull-down request for the shared line, high means pull low |

## Verification
The overcurrent trip and an external disable can hit the same clock edge. The bench provokes this by raising `oc_flag` and pulling the modelled shared line low on the same clock phase while the gate is on and past blanking. Both inputs then reach the logic through their synchronizers on the same edge. The expected result is the trip, not the plain disable: the gate drops, `line_pull` rises, and the line stays pulled after the external pull and the overcurrent both go away, until the full hold time has run. A bench that saw only the disable would instead find `line_pull` low.

// File: rtl/gfc_pkg.sv
package gfc_pkg;

    // Synchronized view of all asynchronous inputs.
    typedef struct packed {
        logic cmd;
        logic oc;
        logic uv_up;
        logic uv_dn;
        logic line;
    } gfc_sense_t;

    localparam int unsigned SENSE_W     = $bits(gfc_sense_t);
    localparam int unsigned SYNC_STAGES = 2;

    // Line and command read low at reset; supply flags read "not good".
    localparam gfc_sense_t SENSE_RST = '{cmd: 1'b0, oc: 1'b0, uv_up: 1'b0,
                                         uv_dn: 1'b0, line: 1'b0};

    typedef enum logic [0:0] {
        HOLD_OFF = 1'b0,
        HOLD_ON  = 1'b1
    } hold_e;

    // Counter width able to hold the value lim.
    function automatic int unsigned cnt_w(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/gfc_sync.sv
module gfc_sync #(
    parameter int unsigned          WIDTH   = 1,
    parameter int unsigned          STAGES  = 2,
    parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gfc_blank.sv
module gfc_blank
    import gfc_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 45
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_rise,
    input  logic gate_on,
    output logic blank_open
);
    localparam int unsigned          BW  = cnt_w(BLANK_CYC);
    localparam logic [BW-1:0]        LIM = BW'(BLANK_CYC);

    logic [BW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                 remain <= '0;
        else if (gate_rise)      remain <= LIM;
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    // Detection is allowed only with the gate on and the window spent.
    assign blank_open = gate_on && (remain == '0);
endmodule

// File: rtl/gfc_uv_guard.sv
module gfc_uv_guard
    import gfc_pkg::*;
#(
    parameter int unsigned UV_FILT_CYC = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic uv_up,
    input  logic uv_dn,
    output logic uv_active,
    output logic uv_trip
);
    localparam int unsigned   UW   = cnt_w(UV_FILT_CYC);
    localparam logic [UW-1:0] LAST = UW'(UV_FILT_CYC - 1);

    logic [UW-1:0] dip_cnt;

    assign uv_trip = !uv_active && uv_dn && (dip_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            uv_active <= 1'b1;
            dip_cnt   <= '0;
        end else if (uv_active) begin
            dip_cnt <= '0;
            if (uv_up && !uv_dn) uv_active <= 1'b0;
        end else if (uv_trip) begin
            uv_active <= 1'b1;
            dip_cnt   <= '0;
        end else if (uv_dn) begin
            dip_cnt <= dip_cnt + 1'b1;
        end else begin
            dip_cnt <= '0;
        end
    end
endmodule

// File: rtl/gfc_fault_hold.sv
module gfc_fault_hold
    import gfc_pkg::*;
#(
    parameter int unsigned CLEAR_CYC = 27500
) (
    input  logic clk,
    input  logic rst,
    input  logic fault_evt,
    input  logic fault_cause,
    output logic held
);
    localparam int unsigned   TW  = cnt_w(CLEAR_CYC);
    localparam logic [TW-1:0] LIM = TW'(CLEAR_CYC);

    hold_e         state;
    logic [TW-1:0] tmr;
    logic          tmr_done;

    assign tmr_done = (tmr == LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HOLD_ON;
            tmr   <= '0;
        end else if (fault_evt) begin
            state <= HOLD_ON;
            tmr   <= '0;
        end else if (state == HOLD_ON) begin
            if (!tmr_done)          tmr   <= tmr + 1'b1;
            else if (!fault_cause)  state <= HOLD_OFF;
        end
    end

    assign held = (state == HOLD_ON);
endmodule

// File: rtl/gate_fault_ctrl.sv
module gate_fault_ctrl
    import gfc_pkg::*;
#(
    parameter int unsigned BLANK_CYC   = 45,
    parameter int unsigned UV_FILT_CYC = 500,
    parameter int unsigned CLEAR_CYC   = 27500
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_in,
    input  logic oc_flag,
    input  logic uv_rise_ok,
    input  logic uv_fall_low,
    input  logic line_sense,
    output logic gate_out,
    output logic line_pull
);
    gfc_sense_t         raw;
    gfc_sense_t         sy;
    logic [SENSE_W-1:0] sy_vec;

    logic gate_q, gate_nxt, gate_rise;
    logic blank_open, oc_trip;
    logic uv_active, uv_trip;
    logic fault_evt, fault_cause, held;

    assign raw = '{cmd: cmd_in, oc: oc_flag, uv_up: uv_rise_ok,
                   uv_dn: uv_fall_low, line: line_sense};

    gfc_sync #(
        .WIDTH  (SENSE_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SENSE_RST)
    ) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(sy_vec)
    );
    assign sy = gfc_sense_t'(sy_vec);

    gfc_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk(clk), .rst(rst), .gate_rise(gate_rise),
        .gate_on(gate_q), .blank_open(blank_open)
    );

    gfc_uv_guard #(.UV_FILT_CYC(UV_FILT_CYC)) u_uv (
        .clk(clk), .rst(rst), .uv_up(sy.uv_up), .uv_dn(sy.uv_dn),
        .uv_active(uv_active), .uv_trip(uv_trip)
    );

    assign oc_trip     = sy.oc && blank_open;
    assign fault_evt   = oc_trip || uv_trip;
    assign fault_cause = uv_active || sy.oc;

    gfc_fault_hold #(.CLEAR_CYC(CLEAR_CYC)) u_hold (
        .clk(clk), .rst(rst), .fault_evt(fault_evt),
        .fault_cause(fault_cause), .held(held)
    );

    // A trip in this cycle drops the gate on the same edge that latches it.
    assign gate_nxt  = sy.cmd && sy.line && !held && !uv_active && !fault_evt;
    assign gate_rise = gate_nxt && !gate_q;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= gate_nxt;
    end

    assign gate_out  = gate_q;
    assign line_pull = held;
endmodule

// File: rtl/gfc_checker.sv
module gfc_checker
    import gfc_pkg::*;
#(
    parameter int unsigned BLANK_CYC   = 45,
    parameter int unsigned UV_FILT_CYC = 500,
    parameter int unsigned CLEAR_CYC   = 27500
) (
    input logic clk,
    input logic rst,
    input logic gate_out,
    input logic line_pull,
    input logic oc_trip,
    input logic uv_trip,
    input logic fault_evt,
    input logic fault_cause,
    input logic uv_active,
    input logic s_cmd,
    input logic s_line,
    input logic s_uvdn
);
    localparam int unsigned   HW = cnt_w(BLANK_CYC);
    localparam int unsigned   EW = cnt_w(CLEAR_CYC);
    localparam int unsigned   DW = cnt_w(UV_FILT_CYC);
    localparam logic [HW-1:0] HMAX = HW'(BLANK_CYC);
    localparam logic [EW-1:0] EMAX = EW'(CLEAR_CYC);
    localparam logic [DW-1:0] DMAX = DW'(UV_FILT_CYC);

    logic [HW-1:0] on_cnt;
    logic [EW-1:0] since_evt;
    logic [DW-1:0] dip_run;

    always_ff @(posedge clk) begin
        if (rst || !gate_out)   on_cnt <= '0;
        else if (on_cnt < HMAX) on_cnt <= on_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || fault_evt)      since_evt <= '0;
        else if (since_evt < EMAX) since_evt <= since_evt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !s_uvdn)      dip_run <= '0;
        else if (dip_run < DMAX) dip_run <= dip_run + 1'b1;
    end

    // R1
    gate_follow_chk: assert property (@(posedge clk) disable iff (rst)
        gate_out |-> ($past(s_cmd) && $past(s_line)));

    // R2
    blank_window_chk: assert property (@(posedge clk) disable iff (rst)
        oc_trip |-> (on_cnt == HMAX));

    // R4
    uv_filter_chk: assert property (@(posedge clk) disable iff (rst)
        uv_trip |-> (32'(dip_run) + 1 >= UV_FILT_CYC));

    // R5
    uv_gate_low_chk: assert property (@(posedge clk) disable iff (rst)
        uv_active |-> !gate_out);

    // R6
    fault_blocks_gate_chk: assert property (@(posedge clk) disable iff (rst)
        line_pull |-> !gate_out);

    // R7
    release_time_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(line_pull) |-> (since_evt == EMAX));

    // R7
    release_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(line_pull) |-> !$past(fault_cause));
endmodule

bind gate_fault_ctrl gfc_checker #(
    .BLANK_CYC  (BLANK_CYC),
    .UV_FILT_CYC(UV_FILT_CYC),
    .CLEAR_CYC  (CLEAR_CYC)
) u_gfc_chk (
    .clk        (clk),
    .rst        (rst),
    .gate_out   (gate_out),
    .line_pull  (line_pull),
    .oc_trip    (oc_trip),
    .uv_trip    (uv_trip),
    .fault_evt  (fault_evt),
    .fault_cause(fault_cause),
    .uv_active  (uv_active),
    .s_cmd      (sy.cmd),
    .s_line     (sy.line),
    .s_uvdn     (sy.uv_dn)
);

// File: tb/test_gate_fault_ctrl.sv
`timescale 1ns/1ps
module test_gate_fault_ctrl;
    localparam int unsigned B = 8;
    localparam int unsigned U = 16;
    localparam int unsigned C = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_in = 1'b0, oc_flag = 1'b0, uv_rise_ok = 1'b0, uv_fall_low = 1'b0;
    logic ext_low = 1'b0;
    logic line_sense, gate_out, line_pull;
    int   checks = 0;
    int   errors = 0;

    always #2 clk = ~clk;

    // Wired-AND shared line: low if the block or an outside agent pulls it.
    assign line_sense = !(ext_low || line_pull);

    gate_fault_ctrl #(.BLANK_CYC(B), .UV_FILT_CYC(U), .CLEAR_CYC(C)) i_gate_fault_ctrl (
        .clk(clk), .rst(rst), .cmd_in(cmd_in), .oc_flag(oc_flag),
        .uv_rise_ok(uv_rise_ok), .uv_fall_low(uv_fall_low),
        .line_sense(line_sense), .gate_out(gate_out), .line_pull(line_pull)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic t_reset_powerup;
        step(4);
        chk("R10", "gate in reset", gate_out, 1'b0);
        chk("R10", "pull in reset", line_pull, 1'b1);
        rst = 1'b0;
        cmd_in = 1'b1;
        step(C + 20);
        chk("R5", "gate before supply good", gate_out, 1'b0);
        chk("R5", "pull before supply good", line_pull, 1'b1);
        uv_rise_ok = 1'b1;
        step(12);
        chk("R5", "pull after supply good", line_pull, 1'b0);
        chk("R5", "gate after supply good", gate_out, 1'b1);
        step(20);
    endtask

    task automatic t_follow;
        cmd_in = 1'b0;
        step(2);
        chk("R1", "gate before 3rd edge (fall)", gate_out, 1'b1);
        step(1);
        chk("R1", "gate at 3rd edge (fall)", gate_out, 1'b0);
        cmd_in = 1'b1;
        step(2);
        chk("R1", "gate before 3rd edge (rise)", gate_out, 1'b0);
        step(1);
        chk("R1", "gate at 3rd edge (rise)", gate_out, 1'b1);
        step(20);
    endtask

    task automatic t_enable;
        ext_low = 1'b1;
        step(3);
        chk("R9", "gate while line held low", gate_out, 1'b0);
        chk("R9", "no pull from outside disable", line_pull, 1'b0);
        ext_low = 1'b0;
        step(3);
        chk("R9", "gate after line released", gate_out, 1'b1);
        chk("R9", "pull after line released", line_pull, 1'b0);
        step(20);
    endtask

    task automatic t_blank_and_persist;
        cmd_in = 1'b0;
        step(5);
        cmd_in = 1'b1;
        step(3);
        chk("R1", "gate on before blank test", gate_out, 1'b1);
        oc_flag = 1'b1;
        step(3);
        oc_flag = 1'b0;
        step(15);
        chk("R2", "gate after pulse in blanking", gate_out, 1'b1);
        chk("R2", "pull after pulse in blanking", line_pull, 1'b0);
        oc_flag = 1'b1;
        step(2);
        chk("R3", "gate before trip edge", gate_out, 1'b1);
        step(1);
        chk("R3", "gate at trip edge", gate_out, 1'b0);
        chk("R3", "pull at trip edge", line_pull, 1'b1);
        step(50);
        chk("R6", "gate held low with cmd high", gate_out, 1'b0);
        step(C + 50);
        chk("R7", "pull while cause outlasts hold", line_pull, 1'b1);
        oc_flag = 1'b0;
        step(4);
        chk("R7", "pull after cause gone", line_pull, 1'b0);
        step(10);
        chk("R1", "gate resumes after release", gate_out, 1'b1);
        step(20);
    endtask

    task automatic t_oc_hold_time;
        oc_flag = 1'b1;
        for (int i = 0; i < 10 && !line_pull; i++) step(1);
        oc_flag = 1'b0;
        chk("R3", "trip seen", line_pull, 1'b1);
        step(C - 2);
        chk("R7", "pull before hold time", line_pull, 1'b1);
        step(4);
        chk("R7", "pull after hold time", line_pull, 1'b0);
        step(20);
    endtask

    task automatic t_uv;
        uv_fall_low = 1'b1;
        step(U - 2);
        uv_fall_low = 1'b0;
        step(10);
        chk("R4", "gate after short dip", gate_out, 1'b1);
        chk("R4", "pull after short dip", line_pull, 1'b0);
        uv_fall_low = 1'b1;
        uv_rise_ok  = 1'b0;
        step(U + 5);
        chk("R4", "gate after long dip", gate_out, 1'b0);
        chk("R4", "pull after long dip", line_pull, 1'b1);
        uv_fall_low = 1'b0;
        uv_rise_ok  = 1'b1;
        step(5);
        chk("R7", "pull kept after supply recovers", line_pull, 1'b1);
        step(C + 10);
        chk("R7", "pull released after uv hold", line_pull, 1'b0);
        step(20);
    endtask

    task automatic t_restart;
        oc_flag = 1'b1;
        for (int i = 0; i < 10 && !line_pull; i++) step(1);
        oc_flag = 1'b0;
        step(100);
        uv_fall_low = 1'b1;
        uv_rise_ok  = 1'b0;
        step(U + 5);
        uv_fall_low = 1'b0;
        uv_rise_ok  = 1'b1;
        step(C + 10 - 100 - (U + 5));
        chk("R8", "pull past first hold time", line_pull, 1'b1);
        step(120);
        chk("R8", "pull after restarted hold", line_pull, 1'b0);
        step(20);
    endtask

    task automatic t_same_cycle;
        oc_flag = 1'b1;
        ext_low = 1'b1;
        step(3);
        chk("R3", "gate with trip and disable together", gate_out, 1'b0);
        chk("R3", "pull with trip and disable together", line_pull, 1'b1);
        step(2);
        oc_flag = 1'b0;
        ext_low = 1'b0;
        step(10);
        chk("R9", "trip latched unlike plain disable", line_pull, 1'b1);
        step(C);
        chk("R7", "pull released after hold", line_pull, 1'b0);
        step(10);
        chk("R1", "gate resumes", gate_out, 1'b1);
    endtask

    initial begin
        t_reset_powerup();
        t_follow();
        t_enable();
        t_blank_and_persist();
        t_oc_hold_time();
        t_uv();
        t_restart();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule